// File: doc/BRIEF.md
# Four-Channel Command-Strobed Interval Timer

This block is a memory-mapped peripheral with four independent 32-bit up-counters. Each counter has its own register window on a small synchronous register bus. The processor sets a terminal value, picks continuous or single-shot operation, unmasks the interrupt and then starts the counter. Starting, stopping and clearing a channel are done by writing to dedicated command addresses. The value written to a command address is discarded.

Each channel advances once per cycle in which its own tick-enable input is high. The channel must be running, and the shared clock-request bit must be set. When the count equals the terminal value on such a tick, the channel latches a pending flag. In continuous operation it then restarts from zero. In single-shot operation it stops and holds the count. The pending flag stays set until software writes to the channel's acknowledge address. The interrupt line is the pending flag gated by the channel's interrupt-enable bit.

Top module: `quad_interval_timer`

## Requirements
- R1: After reset, every channel reads count 0, terminal value 0xFFFFFFFF and status 0x01. The clock-request register reads 0, and all interrupt lines are low.
- R2: A channel's count rises by one only in a cycle where all three of these hold: the channel is running, clock-request bit 0 (address 0x100) is 1, and that channel's tick-enable bit is 1. In any other cycle the count is unchanged.
- R3: In continuous mode (mode register bit 0 = 0), a qualifying tick with count equal to the terminal value does three things: the count goes to 0, the pending flag is set, and the channel keeps running.
- R4: In single-shot mode (mode bit 0 = 1), a qualifying tick with count equal to the terminal value does three things: the pending flag is set, the channel stops, and the count holds at the terminal value.
- R5: A write to channel offset 0x00 clears the count and the pending flag and stops the channel, whatever the data is.
- R6: A write to offset 0x04 starts the channel, and a write to offset 0x08 stops it with the count frozen. The data is ignored in both cases, and no counting happens in the cycle of either command.
- R7: The status register (offset 0x10) reads as follows. Bits [3:0] are 1 when the channel is stopped and 2 when it is running. Bit 4 is the running flag, bit 5 is the mode bit, bit 6 is the interrupt-enable bit and bit 7 is the pending flag. The upper bits read 0.
- R8: The interrupt line of a channel equals its pending flag ANDed with bit 0 of its interrupt-enable register (offset 0x1C). The pending flag is set even while the line is masked.
- R9: A write to offset 0x20 clears the pending flag when data bit 7 is 1 and has no effect otherwise. If a terminal match occurs in the same cycle, the flag stays set.
- R10: Channel windows start at 0x00, 0x40, 0x80 and 0xC0. Count is at +0x14, terminal value at +0x18 and mode at +0x0C. Reads of the command, mode, interrupt-enable and acknowledge offsets, and of unmapped addresses, return 0.
- R11: A write or tick aimed at one channel leaves the registers and interrupt line of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 4 | Per-channel count-enable pulses |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The assertions assume that each write strobe lasts one cycle. They also assume that the address is stable while the strobe is high. Tick-enable inputs may arrive in any cycle, including a cycle that carries a command or an acknowledge for the same channel. The stimulus uses single-cycle writes only. It mixes them with ticks that are independently random per channel. It also picks small terminal values so that matches collide often with commands and acknowledges.

// File: rtl/qit_pkg.sv
// Shared constants and types for the four-channel interval timer.
// Assumes byte addressing with 32-bit aligned registers.
package qit_pkg;
    localparam int N_CH     = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 9;
    localparam int WIN_BITS = 6;                 // 64-byte window per channel

    localparam logic [WIN_BITS-1:0] OFS_RESET  = 6'h00;
    localparam logic [WIN_BITS-1:0] OFS_START  = 6'h04;
    localparam logic [WIN_BITS-1:0] OFS_STOP   = 6'h08;
    localparam logic [WIN_BITS-1:0] OFS_MODE   = 6'h0C;
    localparam logic [WIN_BITS-1:0] OFS_STAT   = 6'h10;
    localparam logic [WIN_BITS-1:0] OFS_COUNT  = 6'h14;
    localparam logic [WIN_BITS-1:0] OFS_TERM   = 6'h18;
    localparam logic [WIN_BITS-1:0] OFS_IRQEN  = 6'h1C;
    localparam logic [WIN_BITS-1:0] OFS_ACK    = 6'h20;
    localparam logic [ADDR_W-1:0]   ADR_CLKREQ = 9'h100;

    localparam int ACK_BIT = 7;

    typedef enum logic [3:0] {
        CH_IDLE    = 4'd1,
        CH_RUNNING = 4'd2
    } ch_state_e;

    typedef struct packed {
        logic pend;
        logic irq_en;
        logic one_shot;
        logic running;
        ch_state_e state;
    } ch_status_t;
endpackage

// File: rtl/qit_bus_decode.sv
// Write decoder: turns one bus write into per-channel command and
// register-write strobes plus the shared clock-request write.
// Assumes bus_wr is a one-cycle strobe with a stable address.
module qit_bus_decode
    import qit_pkg::*;
#(
    parameter int NCH = N_CH,
    parameter int AW  = ADDR_W
) (
    input  logic [AW-1:0]  addr_i,
    input  logic           wr_i,
    output logic [NCH-1:0] cmd_rst_o,
    output logic [NCH-1:0] cmd_start_o,
    output logic [NCH-1:0] cmd_stop_o,
    output logic [NCH-1:0] wr_mode_o,
    output logic [NCH-1:0] wr_term_o,
    output logic [NCH-1:0] wr_irqen_o,
    output logic [NCH-1:0] wr_ack_o,
    output logic           wr_clkreq_o
);
    localparam int SEL_W = AW - 1 - WIN_BITS;

    logic               in_ch_space;
    logic [SEL_W-1:0]   ch_sel;
    logic [WIN_BITS-1:0] ofs;

    assign in_ch_space = ~addr_i[AW-1];
    assign ch_sel      = addr_i[AW-2:WIN_BITS];
    assign ofs         = addr_i[WIN_BITS-1:0];
    assign wr_clkreq_o = wr_i && (addr_i == ADR_CLKREQ);

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        logic hit;
        // Per-channel window select, then offset decode.
        always_comb begin
            hit             = wr_i && in_ch_space && (ch_sel == SEL_W'(g));
            cmd_rst_o[g]    = hit && (ofs == OFS_RESET);
            cmd_start_o[g]  = hit && (ofs == OFS_START);
            cmd_stop_o[g]   = hit && (ofs == OFS_STOP);
            wr_mode_o[g]    = hit && (ofs == OFS_MODE);
            wr_term_o[g]    = hit && (ofs == OFS_TERM);
            wr_irqen_o[g]   = hit && (ofs == OFS_IRQEN);
            wr_ack_o[g]     = hit && (ofs == OFS_ACK);
        end
    end
endmodule

// File: rtl/qit_channel.sv
// One interval-timer channel: 32-bit up-counter, terminal compare,
// continuous or single-shot operation, pending flag and masked IRQ.
// Assumes tick_i is already qualified by the shared clock request.
// Priority: reset command > stop/start command > counting.
module qit_channel
    import qit_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          cmd_rst_i,
    input  logic          cmd_start_i,
    input  logic          cmd_stop_i,
    input  logic          wr_mode_i,
    input  logic          wr_term_i,
    input  logic          wr_irqen_i,
    input  logic          wr_ack_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] term_o,
    output ch_status_t    status_o,
    output logic          irq_o
);
    logic [DW-1:0] count_q, term_q;
    logic          running_q, one_shot_q, irq_en_q, pend_q;
    logic          advance, hit, ack_clr, cmd_any;

    // Qualify this cycle's tick and detect a terminal match.
    always_comb begin
        cmd_any = cmd_start_i || cmd_stop_i;
        advance = tick_i && running_q && !cmd_any && !cmd_rst_i;
        hit     = advance && (count_q == term_q);
        ack_clr = wr_ack_i && wdata_i[ACK_BIT];
    end

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q     <= '1;
            one_shot_q <= 1'b0;
            irq_en_q   <= 1'b0;
        end else begin
            if (wr_term_i)  term_q     <= wdata_i;
            if (wr_mode_i)  one_shot_q <= wdata_i[0];
            if (wr_irqen_i) irq_en_q   <= wdata_i[0];
        end
    end

    // Run state, counter and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            running_q <= 1'b0;
            pend_q    <= 1'b0;
        end else if (cmd_rst_i) begin
            count_q   <= '0;
            running_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            if (cmd_stop_i)                running_q <= 1'b0;
            else if (cmd_start_i)          running_q <= 1'b1;
            else if (hit && one_shot_q)    running_q <= 1'b0;

            if (advance) begin
                if (!hit)                  count_q <= count_q + 1'b1;
                else if (!one_shot_q)      count_q <= '0;
            end

            if (hit)                       pend_q <= 1'b1;
            else if (ack_clr)              pend_q <= 1'b0;
        end
    end

    // Status packing and the masked interrupt line.
    always_comb begin
        status_o.pend     = pend_q;
        status_o.irq_en   = irq_en_q;
        status_o.one_shot = one_shot_q;
        status_o.running  = running_q;
        status_o.state    = running_q ? CH_RUNNING : CH_IDLE;
        irq_o             = pend_q & irq_en_q;
    end

    assign count_o = count_q;
    assign term_o  = term_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cmd_rst_i) |=> $stable(count_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && running_q && !cmd_any && !cmd_rst_i && count_q != term_q)
        |=> (count_q == $past(count_q) + 1'b1)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !one_shot_q) |=> (count_q == '0 && pend_q && running_q)); // R3
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && one_shot_q) |=> (!running_q && pend_q && $stable(count_q))); // R4
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_i |=> (count_q == '0 && !pend_q && !running_q)); // R5
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop_i && !cmd_rst_i) |=> (!running_q && $stable(count_q))); // R6
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !hit && !cmd_rst_i) |=> !pend_q); // R9
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_q); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !irq_o); // R8
endmodule

// File: rtl/qit_read_mux.sv
// Read-data multiplexer for all channel windows and the shared
// clock-request register. Write-only and unmapped addresses read 0.
module qit_read_mux
    import qit_pkg::*;
#(
    parameter int NCH = N_CH,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W
) (
    input  logic [AW-1:0]          addr_i,
    input  logic [NCH-1:0][DW-1:0] count_i,
    input  logic [NCH-1:0][DW-1:0] term_i,
    input  ch_status_t [NCH-1:0]   status_i,
    input  logic                   clkreq_i,
    output logic [DW-1:0]          rdata_o
);
    localparam int SEL_W = AW - 1 - WIN_BITS;

    // Select a channel by address bits, then the register by offset.
    always_comb begin
        logic [SEL_W-1:0]    ch;
        logic [WIN_BITS-1:0] ofs;
        ch      = addr_i[AW-2:WIN_BITS];
        ofs     = addr_i[WIN_BITS-1:0];
        rdata_o = '0;
        if (addr_i == ADR_CLKREQ) begin
            rdata_o = DW'(clkreq_i);
        end else if (!addr_i[AW-1]) begin
            case (ofs)
                OFS_STAT:  rdata_o = DW'(status_i[ch]);
                OFS_COUNT: rdata_o = count_i[ch];
                OFS_TERM:  rdata_o = term_i[ch];
                default:   rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/quad_interval_timer.sv
// Top level: four interval-timer channels behind a simple register bus,
// with a shared clock-request bit gating every channel's tick input.
// Assumes one-cycle write strobes; reads are combinational.
module quad_interval_timer
    import qit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [8:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [3:0]  tick_en,
    output logic [3:0]  irq
);
    logic [N_CH-1:0] cmd_rst, cmd_start, cmd_stop;
    logic [N_CH-1:0] wr_mode, wr_term, wr_irqen, wr_ack;
    logic            wr_clkreq, clkreq_q;
    logic [N_CH-1:0][DATA_W-1:0] count_all, term_all;
    ch_status_t [N_CH-1:0]       status_all;

    // Shared clock-request bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         clkreq_q <= 1'b0;
        else if (wr_clkreq) clkreq_q <= bus_wdata[0];
    end

    qit_bus_decode #(.NCH(N_CH), .AW(ADDR_W)) dec_i (
        .addr_i      (bus_addr),
        .wr_i        (bus_wr),
        .cmd_rst_o   (cmd_rst),
        .cmd_start_o (cmd_start),
        .cmd_stop_o  (cmd_stop),
        .wr_mode_o   (wr_mode),
        .wr_term_o   (wr_term),
        .wr_irqen_o  (wr_irqen),
        .wr_ack_o    (wr_ack),
        .wr_clkreq_o (wr_clkreq)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        qit_channel #(.DW(DATA_W)) ch_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_en[g] & clkreq_q),
            .cmd_rst_i   (cmd_rst[g]),
            .cmd_start_i (cmd_start[g]),
            .cmd_stop_i  (cmd_stop[g]),
            .wr_mode_i   (wr_mode[g]),
            .wr_term_i   (wr_term[g]),
            .wr_irqen_i  (wr_irqen[g]),
            .wr_ack_i    (wr_ack[g]),
            .wdata_i     (bus_wdata),
            .count_o     (count_all[g]),
            .term_o      (term_all[g]),
            .status_o    (status_all[g]),
            .irq_o       (irq[g])
        );
    end

    qit_read_mux #(.NCH(N_CH), .DW(DATA_W), .AW(ADDR_W)) rmux_i (
        .addr_i   (bus_addr),
        .count_i  (count_all),
        .term_i   (term_all),
        .status_i (status_all),
        .clkreq_i (clkreq_q),
        .rdata_o  (bus_rdata)
    );

    AST_CLKREQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clkreq_q && !bus_wr) |=> ($stable(count_all))); // R2
    AST_ONEHOT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_rst, cmd_start, cmd_stop, wr_ack})); // R11
endmodule

// File: tb/quad_interval_timer_tb_top.sv
module quad_interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en = '0;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state per channel.
    logic [31:0] m_cnt [4];
    logic [31:0] m_tc  [4];
    logic        m_os  [4];
    logic        m_ie  [4];
    logic        m_pd  [4];
    logic        m_run [4];
    logic        m_crq;

    always #5 clk = ~clk;

    quad_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq(irq)
    );

    function automatic logic [31:0] exp_status(int c);
        return {24'd0, m_pd[c], m_ie[c], m_os[c], m_run[c],
                m_run[c] ? 4'd2 : 4'd1};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_cnt[c] = 0; m_tc[c] = 32'hFFFF_FFFF; m_os[c] = 0;
            m_ie[c] = 0; m_pd[c] = 0; m_run[c] = 0;
        end
        m_crq = 0;
    endtask

    // Apply one clock of bus activity to the reference model.
    task automatic model_update(logic wr, logic [8:0] a, logic [31:0] d, logic [3:0] tk);
        for (int c = 0; c < 4; c++) begin
            logic sel, rs, st, sp, ad, hit;
            sel = wr && !a[8] && (a[7:6] == c[1:0]);
            rs = sel && a[5:0] == 6'h00;
            st = sel && a[5:0] == 6'h04;
            sp = sel && a[5:0] == 6'h08;
            ad = tk[c] && m_crq && m_run[c] && !rs && !st && !sp;
            hit = ad && (m_cnt[c] == m_tc[c]);
            if (rs) begin
                m_cnt[c] = 0; m_pd[c] = 0; m_run[c] = 0;
            end else begin
                if (hit) begin
                    m_pd[c] = 1;
                    if (m_os[c]) m_run[c] = 0; else m_cnt[c] = 0;
                end else if (ad) m_cnt[c] = m_cnt[c] + 1;
                if (!hit && sel && a[5:0] == 6'h20 && d[7]) m_pd[c] = 0;
                if (sp) m_run[c] = 0; else if (st) m_run[c] = 1;
            end
            if (sel && a[5:0] == 6'h0C) m_os[c] = d[0];
            if (sel && a[5:0] == 6'h18) m_tc[c] = d;
            if (sel && a[5:0] == 6'h1C) m_ie[c] = d[0];
        end
        if (wr && a == 9'h100) m_crq = d[0];
    endtask

    task automatic step(logic wr, logic [8:0] a, logic [31:0] d, logic [3:0] tk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(posedge clk);
        model_update(wr, a, d, tk);
        #1;
        bus_wr = 0; tick_en = 0;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic check_chan(int c, string req);
        logic [31:0] v;
        logic [8:0] b;
        b = 9'(c * 64);
        rd(b + 9'h14, v); chk(req, v, m_cnt[c]);
        rd(b + 9'h10, v); chk(req, v, exp_status(c));
        rd(b + 9'h18, v); chk(req, v, m_tc[c]);
        chk(req, 32'(irq[c]), 32'(m_pd[c] & m_ie[c]));
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < 4; c++) check_chan(c, req);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset values, literal expectations.
        rd(9'h050, v); chk("R1 status", v, 32'h01);
        rd(9'h098, v); chk("R1 term", v, 32'hFFFF_FFFF);
        rd(9'h100, v); chk("R1 clkreq", v, 0);
        chk("R1 irq", 32'(irq), 0);
        check_all("R1");

        // R10: write-only and unmapped reads.
        rd(9'h04C, v); chk("R10 mode reads 0", v, 0);
        rd(9'h0E0, v); chk("R10 ack reads 0", v, 0);
        rd(9'h1F0, v); chk("R10 unmapped", v, 0);

        // R2: running but clock request off -> no counting.
        step(1, 9'h044, 32'hDEAD, 0);            // start channel 1
        step(0, 0, 0, 4'hF); step(0, 0, 0, 4'hF);
        rd(9'h054, v); chk("R2 gated count", v, 0);
        step(1, 9'h100, 1, 0);
        step(0, 0, 0, 4'h2); step(0, 0, 0, 4'h2); step(0, 0, 0, 4'h0);
        rd(9'h054, v); chk("R2 count two ticks", v, 2);
        check_all("R11 other channels untouched");

        // R3: continuous wrap with terminal 3, interrupt enabled.
        step(1, 9'h000, 32'h55, 0);
        step(1, 9'h018, 3, 0);
        step(1, 9'h01C, 1, 0);
        step(1, 9'h004, 0, 0);
        repeat (4) step(0, 0, 0, 4'h1);
        rd(9'h014, v); chk("R3 wrapped to 0", v, 0);
        rd(9'h010, v); chk("R7 status running+pend+ie", v, 32'hD2);
        chk("R8 irq high", 32'(irq[0]), 1);

        // R9: ack without bit 7 has no effect; with bit 7 clears.
        step(1, 9'h020, 32'h7F, 0);
        check_chan(0, "R9 ack bit7 clear ignored");
        step(1, 9'h020, 32'h80, 0);
        rd(9'h010, v); chk("R9 ack clears", v, 32'h52);

        // R9: ack collides with a match -> stays pending.
        step(1, 9'h018, 0, 0);
        step(1, 9'h020, 32'h80, 4'h1);
        rd(9'h010, v); chk("R9 match wins", v, 32'hD2);

        // R4 + R8: single-shot on channel 2 with IRQ masked.
        step(1, 9'h08C, 1, 0);
        step(1, 9'h098, 2, 0);
        step(1, 9'h084, 0, 0);
        repeat (5) step(0, 0, 0, 4'h4);
        rd(9'h094, v); chk("R4 holds at terminal", v, 2);
        rd(9'h090, v); chk("R4 R7 idle oneshot pend", v, 32'hA1);
        chk("R8 masked irq", 32'(irq[2]), 0);

        // R6: stop freezes, start resumes; R5 reset with data.
        step(1, 9'h0C4, 0, 0);
        step(0, 0, 0, 4'h8); step(0, 0, 0, 4'h8);
        step(1, 9'h0C8, 32'hFFFF_FFFF, 4'h8);
        step(0, 0, 0, 4'h8);
        rd(9'h0D4, v); chk("R6 frozen", v, 2);
        step(1, 9'h0C4, 32'h1234, 4'h8);
        rd(9'h0D4, v); chk("R6 no count on start cycle", v, 2);
        step(1, 9'h0C0, 32'hFFFF_FFFF, 4'h8);
        rd(9'h0D0, v); chk("R5 reset", v, 32'h01);
        check_all("R5 R6 model");

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            int c, k;
            logic [8:0]  a;
            logic [31:0] d;
            logic [5:0]  ofs;
            c = int'($urandom_range(0, 3));
            k = int'($urandom_range(0, 9));
            case (k)
                0: ofs = 6'h00;  1: ofs = 6'h04;  2: ofs = 6'h08;
                3: ofs = 6'h0C;  4: ofs = 6'h18;  5: ofs = 6'h1C;
                6: ofs = 6'h20;  7: ofs = 6'h10;  default: ofs = 6'h04;
            endcase
            a = {1'b0, c[1:0], ofs};
            d = $urandom;
            if (ofs == 6'h18) d = $urandom_range(0, 6);
            if ($urandom_range(0, 49) == 0) a = 9'h100;
            if (a == 9'h100) d = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 2) == 0)
                step(1, a, d, 4'($urandom));
            else
                step(0, 0, 0, 4'($urandom));
            check_chan(int'($urandom_range(0, 3)), "R2 R3 R4 R9 R11 random");
        end
        check_all("R7 final");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule